// File: doc/BRIEF.md
# Two-Way MMIO Port Splitter

This block lives inside a scalability switch. Every request that reaches it carries a 40-bit address, a two-bit attribute and a domain index. Only requests whose attribute marks them as memory-mapped I/O are steered. Each such request goes to one of two I/O hub ports. Any other request is flagged as pass-through, and the switch routes it elsewhere.

Each domain has its own pair of split boundaries, one for the region below 4 GB and one for the region at or above 4 GB. Each boundary has its own two-bit mode. A mode can send the whole range to port 0, send the whole range to port 1, or split the range at the boundary. When the range is split, port 0 takes the upper part. The low boundary counts in 64 MB steps and the high boundary counts in 4 GB steps. The decision is registered and comes out one cycle later, qualified by a valid flag.

Top module: `mmio_port_split`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `req_valid` high. While `rst_n` is low at a clock edge, all outputs are cleared at that edge.
- R2: A valid request whose `req_attr` is not 2'b10 (the MMIO code) yields `out_pass`=1 and `out_port`=0.
- R3: An MMIO request with `req_addr[39:32]`==0 is routed by the low mode and low boundary of its domain. Any other MMIO request is routed by the high mode and high boundary.
- R4: Mode 2'b00 sends every address in the range to port 0. Mode 2'b01 sends every address in the range to port 1.
- R5: With low mode 2'b10, an address with `req_addr[31:26]` >= the domain's 6-bit low boundary goes to port 0. A lower address goes to port 1.
- R6: With high mode 2'b10, an address with `req_addr[39:32]` >= the domain's 8-bit high boundary goes to port 0. A lower address goes to port 1.
- R7: Mode 2'b11 is reserved and behaves as 2'b00 (port 0).
- R8: Domain d uses the fields at bits [d*6 +: 6] of `lo_bound_flat`, [d*8 +: 8] of `hi_bound_flat` and [d*2 +: 2] of each mode bus. No other domain's settings affect its result.
- R9: Whenever `out_valid` is low, `out_pass` and `out_port` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 40 | Request address |
| req_attr | input | 2 | Request attribute, 2'b10 = MMIO |
| req_dom | input | 2 | Domain index |
| lo_bound_flat | input | 24 | Per-domain low split boundary, 64 MB units |
| hi_bound_flat | input | 32 | Per-domain high split boundary, 4 GB units |
| lo_mode_flat | input | 8 | Per-domain low range mode |
| hi_mode_flat | input | 8 | Per-domain high range mode |
| out_valid | output | 1 | Registered decision valid |
| out_pass | output | 1 | Request is not MMIO and passes through |
| out_port | output | 1 | Selected I/O hub port |

## Verification
Two functions can bear on the same request in the same cycle: choosing the low or high register set from the 4 GB test, and applying a split boundary. The bench provokes both at once. It gives one domain different low and high modes, then sends the addresses just below and at 4 GB. It also places boundaries so that the split edge falls on a single 64 MB or 4 GB step. Each registered result is compared with the route a bench function computes from the requirements. Random traffic then mixes domains, attributes and boundary values, so these overlaps recur under many settings.

// File: rtl/mmio_split_pkg.sv
// Package: shared codes for the MMIO port splitter.
// Assumes a two-bit attribute field and two-bit range modes.
package mmio_split_pkg;
    localparam logic [1:0] ATTR_MMIO = 2'b10;

    typedef enum logic [1:0] {
        MODE_ALL0  = 2'b00,
        MODE_ALL1  = 2'b01,
        MODE_SPLIT = 2'b10,
        MODE_RSVD  = 2'b11
    } range_mode_e;
endpackage

// File: rtl/mmio_dom_select.sv
// Module: picks one domain's boundaries and modes out of the flat buses.
// Assumes an index at or above NUM_DOM selects all-zero settings.
module mmio_dom_select #(
    parameter int NUM_DOM = 4,
    parameter int LO_W    = 6,
    parameter int HI_W    = 8,
    localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic [DOM_W-1:0]        dom,
    input  logic [NUM_DOM*LO_W-1:0] lo_bound_flat,
    input  logic [NUM_DOM*HI_W-1:0] hi_bound_flat,
    input  logic [NUM_DOM*2-1:0]    lo_mode_flat,
    input  logic [NUM_DOM*2-1:0]    hi_mode_flat,
    output logic [LO_W-1:0]         lo_bound,
    output logic [HI_W-1:0]         hi_bound,
    output logic [1:0]              lo_mode,
    output logic [1:0]              hi_mode
);
    logic [LO_W-1:0] lo_b_arr [NUM_DOM];
    logic [HI_W-1:0] hi_b_arr [NUM_DOM];
    logic [1:0]      lo_m_arr [NUM_DOM];
    logic [1:0]      hi_m_arr [NUM_DOM];

    // Unpack each domain's fields into arrays.
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_unpack
        assign lo_b_arr[d] = lo_bound_flat[d*LO_W +: LO_W];
        assign hi_b_arr[d] = hi_bound_flat[d*HI_W +: HI_W];
        assign lo_m_arr[d] = lo_mode_flat[d*2 +: 2];
        assign hi_m_arr[d] = hi_mode_flat[d*2 +: 2];
    end

    // Select the requested domain, or zeros when the index is out of range.
    always_comb begin
        lo_bound = '0;
        hi_bound = '0;
        lo_mode  = '0;
        hi_mode  = '0;
        if (int'(dom) < NUM_DOM) begin
            lo_bound = lo_b_arr[dom];
            hi_bound = hi_b_arr[dom];
            lo_mode  = lo_m_arr[dom];
            hi_mode  = hi_m_arr[dom];
        end
    end
endmodule

// File: rtl/mmio_split_decide.sv
// Module: combinational routing decision for one request.
// Assumes the upper part of a split range belongs to port 0.
module mmio_split_decide
    import mmio_split_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int LO_LSB    = 26,
    parameter int HI_LSB    = 32,
    localparam int LO_W     = HI_LSB - LO_LSB,
    localparam int HI_W     = ADDR_W - HI_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        attr,
    input  logic [LO_W-1:0]   lo_bound,
    input  logic [HI_W-1:0]   hi_bound,
    input  logic [1:0]        lo_mode,
    input  logic [1:0]        hi_mode,
    output logic              pass,
    output logic              port
);
    logic        below_4g;
    logic [1:0]  mode;
    logic        at_or_above;

    // Choose the register set from the 4 GB test and compare against its boundary.
    always_comb begin
        below_4g    = (addr[ADDR_W-1:HI_LSB] == '0);
        mode        = below_4g ? lo_mode : hi_mode;
        at_or_above = below_4g ? (addr[HI_LSB-1:LO_LSB] >= lo_bound)
                               : (addr[ADDR_W-1:HI_LSB] >= hi_bound);
    end

    // Map the mode to a port, or flag non-MMIO traffic as pass-through.
    always_comb begin
        pass = (attr != ATTR_MMIO);
        port = 1'b0;
        if (!pass) begin
            unique case (range_mode_e'(mode))
                MODE_ALL1:  port = 1'b1;
                MODE_SPLIT: port = ~at_or_above;
                default:    port = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mmio_port_split.sv
// Module: top of the MMIO port splitter; registers the routing decision.
// Assumes one request per cycle and no back-pressure.
module mmio_port_split #(
    parameter int ADDR_W   = 40,
    parameter int NUM_DOM  = 4,
    parameter int LO_LSB   = 26,
    parameter int HI_LSB   = 32,
    localparam int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
    localparam int LO_W    = HI_LSB - LO_LSB,
    localparam int HI_W    = ADDR_W - HI_LSB
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_attr,
    input  logic [DOM_W-1:0]        req_dom,
    input  logic [NUM_DOM*LO_W-1:0] lo_bound_flat,
    input  logic [NUM_DOM*HI_W-1:0] hi_bound_flat,
    input  logic [NUM_DOM*2-1:0]    lo_mode_flat,
    input  logic [NUM_DOM*2-1:0]    hi_mode_flat,
    output logic                    out_valid,
    output logic                    out_pass,
    output logic                    out_port
);
    logic [LO_W-1:0] sel_lo_bound;
    logic [HI_W-1:0] sel_hi_bound;
    logic [1:0]      sel_lo_mode;
    logic [1:0]      sel_hi_mode;
    logic            nxt_pass;
    logic            nxt_port;

    mmio_dom_select #(
        .NUM_DOM (NUM_DOM),
        .LO_W    (LO_W),
        .HI_W    (HI_W)
    ) u_sel (
        .dom           (req_dom),
        .lo_bound_flat (lo_bound_flat),
        .hi_bound_flat (hi_bound_flat),
        .lo_mode_flat  (lo_mode_flat),
        .hi_mode_flat  (hi_mode_flat),
        .lo_bound      (sel_lo_bound),
        .hi_bound      (sel_hi_bound),
        .lo_mode       (sel_lo_mode),
        .hi_mode       (sel_hi_mode)
    );

    mmio_split_decide #(
        .ADDR_W (ADDR_W),
        .LO_LSB (LO_LSB),
        .HI_LSB (HI_LSB)
    ) u_dec (
        .addr     (req_addr),
        .attr     (req_attr),
        .lo_bound (sel_lo_bound),
        .hi_bound (sel_hi_bound),
        .lo_mode  (sel_lo_mode),
        .hi_mode  (sel_hi_mode),
        .pass     (nxt_pass),
        .port     (nxt_port)
    );

    // Register the decision; outputs stay zero when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pass  <= 1'b0;
            out_port  <= 1'b0;
        end else begin
            out_valid <= req_valid;
            out_pass  <= req_valid & nxt_pass;
            out_port  <= req_valid & nxt_port;
        end
    end
endmodule

// File: rtl/mmio_port_split_chk.sv
// Module: property checker bound to mmio_port_split.
// Assumes the attribute and mode codes listed in the brief.
module mmio_port_split_chk #(
    parameter int ADDR_W   = 40,
    parameter int NUM_DOM  = 4,
    parameter int LO_LSB   = 26,
    parameter int HI_LSB   = 32,
    localparam int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
    localparam int LO_W    = HI_LSB - LO_LSB,
    localparam int HI_W    = ADDR_W - HI_LSB
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic [ADDR_W-1:0]       req_addr,
    input logic [1:0]              req_attr,
    input logic [DOM_W-1:0]        req_dom,
    input logic [NUM_DOM*2-1:0]    lo_mode_flat,
    input logic [NUM_DOM*2-1:0]    hi_mode_flat,
    input logic                    out_valid,
    input logic                    out_pass,
    input logic                    out_port
);
    logic [1:0] chk_mode;
    logic       chk_mmio;

    // Independently look up the mode that governs the current request.
    always_comb begin
        chk_mmio = (req_attr == 2'b10);
        if (req_addr[ADDR_W-1:HI_LSB] == '0)
            chk_mode = lo_mode_flat[int'(req_dom)*2 +: 2];
        else
            chk_mode = hi_mode_flat[int'(req_dom)*2 +: 2];
    end

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    a_r2_non_mmio_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !chk_mmio) |=> (out_pass && !out_port));
    a_r4_all1_port1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_mmio && chk_mode == 2'b01) |=> (out_port && !out_pass));
    a_r4_all0_port0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_mmio && chk_mode == 2'b00) |=> (!out_port && !out_pass));
    a_r7_rsvd_port0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_mmio && chk_mode == 2'b11) |=> !out_port);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_pass && !out_port));
endmodule

bind mmio_port_split mmio_port_split_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_DOM (NUM_DOM),
    .LO_LSB  (LO_LSB),
    .HI_LSB  (HI_LSB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_attr     (req_attr),
    .req_dom      (req_dom),
    .lo_mode_flat (lo_mode_flat),
    .hi_mode_flat (hi_mode_flat),
    .out_valid    (out_valid),
    .out_pass     (out_pass),
    .out_port     (out_port)
);

// File: tb/test_mmio_port_split.sv
`timescale 1ns/1ps
module test_mmio_port_split;
    localparam int ND = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [39:0] req_addr;
    logic [1:0]  req_attr;
    logic [1:0]  req_dom;
    logic [ND*6-1:0] lo_bound_flat;
    logic [ND*8-1:0] hi_bound_flat;
    logic [ND*2-1:0] lo_mode_flat;
    logic [ND*2-1:0] hi_mode_flat;
    logic        out_valid, out_pass, out_port;

    logic [5:0] lo_b [ND];
    logic [7:0] hi_b [ND];
    logic [1:0] lo_m [ND];
    logic [1:0] hi_m [ND];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // Pack the bench configuration arrays onto the flat buses.
    always_comb begin
        for (int d = 0; d < ND; d++) begin
            lo_bound_flat[d*6 +: 6] = lo_b[d];
            hi_bound_flat[d*8 +: 8] = hi_b[d];
            lo_mode_flat[d*2 +: 2]  = lo_m[d];
            hi_mode_flat[d*2 +: 2]  = hi_m[d];
        end
    end

    mmio_port_split i_mmio_port_split (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_attr(req_attr), .req_dom(req_dom), .lo_bound_flat(lo_bound_flat),
        .hi_bound_flat(hi_bound_flat), .lo_mode_flat(lo_mode_flat),
        .hi_mode_flat(hi_mode_flat), .out_valid(out_valid), .out_pass(out_pass),
        .out_port(out_port)
    );

    // Expected route computed from the requirements.
    function automatic void ref_route(input logic [39:0] a, input logic [1:0] at,
                                      input int d, output logic pass, output logic port);
        logic [1:0] m;
        logic hi_side;
        pass = (at != 2'b10);
        port = 1'b0;
        if (pass) return;
        hi_side = (a[39:32] != 8'd0);
        m = hi_side ? hi_m[d] : lo_m[d];
        case (m)
            2'b01: port = 1'b1;
            2'b10: port = hi_side ? (a[39:32] < hi_b[d]) : (a[31:26] < lo_b[d]);
            default: port = 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Drive one request, then check the registered result after the next edge.
    task automatic send(input logic v, input logic [39:0] a, input logic [1:0] at,
                        input logic [1:0] d, input string tag);
        logic ep, eo;
        @(negedge clk);
        req_valid = v; req_addr = a; req_attr = at; req_dom = d;
        ref_route(a, at, int'(d), ep, eo);
        @(posedge clk); #1;
        check(tag, "valid", out_valid, v);
        check(tag, "pass",  out_pass,  v & ep);
        check(tag, "port",  out_port,  v & eo);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int d = 0; d < ND; d++) begin
            lo_b[d] = 6'd0; hi_b[d] = 8'd0; lo_m[d] = 2'b00; hi_m[d] = 2'b00;
        end
        rst_n = 1'b0; req_valid = 1'b1; req_addr = '0; req_attr = 2'b10; req_dom = '0;
        lo_m[0] = 2'b01;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset clears outputs even while a request is offered.
        check("R1", "reset valid", out_valid, 1'b0);
        check("R1", "reset port",  out_port,  1'b0);
        @(negedge clk); rst_n = 1'b1; req_valid = 1'b0;

        // Directed configuration.
        lo_m[0] = 2'b10; lo_b[0] = 6'd8;                  // R5 low split
        hi_m[1] = 2'b10; hi_b[1] = 8'd5;                  // R6 high split
        lo_m[2] = 2'b01; hi_m[2] = 2'b00;                 // R3 4 GB edge
        lo_m[3] = 2'b11; hi_m[3] = 2'b11;                 // R7 reserved
        hi_m[0] = 2'b01;

        send(1'b1, 40'd8 << 26,         2'b10, 2'd0, "R5");
        send(1'b1, (40'd8 << 26) - 1,   2'b10, 2'd0, "R5");
        send(1'b1, 40'd5 << 32,         2'b10, 2'd1, "R6");
        send(1'b1, (40'd5 << 32) - 1,   2'b10, 2'd1, "R6");
        send(1'b1, 40'hFF_FFFF_FFFF,    2'b10, 2'd1, "R6");
        send(1'b1, 40'h00_FFFF_FFFF,    2'b10, 2'd2, "R3");
        send(1'b1, 40'h01_0000_0000,    2'b10, 2'd2, "R3");
        send(1'b1, 40'h00_FFFF_FFFF,    2'b10, 2'd0, "R3");
        send(1'b1, 40'h01_0000_0000,    2'b10, 2'd0, "R4");
        send(1'b1, 40'h00_0400_0000,    2'b10, 2'd3, "R7");
        send(1'b1, 40'h80_0000_0000,    2'b10, 2'd3, "R7");
        send(1'b1, 40'h00_1000_0000,    2'b10, 2'd2, "R8");
        send(1'b1, 40'h00_1000_0000,    2'b10, 2'd3, "R8");
        send(1'b1, 40'h00_0000_0000,    2'b10, 2'd0, "R5");
        send(1'b1, 40'h00_1000_0000,    2'b00, 2'd2, "R2");
        send(1'b1, 40'h12_0000_0000,    2'b11, 2'd1, "R2");
        send(1'b0, 40'h00_1000_0000,    2'b10, 2'd2, "R9");
        send(1'b1, 40'h00_1000_0000,    2'b10, 2'd2, "R1");

        // Constrained random traffic with occasional reconfiguration.
        for (int i = 0; i < 3000; i++) begin
            logic [39:0] a;
            logic [1:0]  at;
            if (i % 50 == 0) begin
                for (int d = 0; d < ND; d++) begin
                    lo_b[d] = 6'($urandom);
                    hi_b[d] = 8'($urandom);
                    lo_m[d] = 2'($urandom);
                    hi_m[d] = 2'($urandom);
                end
            end
            a = {8'($urandom), 32'($urandom)};
            if ($urandom % 2 == 0) a[39:32] = 8'd0;
            at = ($urandom % 4 == 0) ? 2'($urandom) : 2'b10;
            send(($urandom % 8) != 0, a, at, 2'($urandom), "R8");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule